// File: doc/BRIEF.md
# Input Capture Unit with Noise Filter

This block records the value of a free-running timer when a chosen edge appears on an asynchronous capture pin. The pin passes through a two-stage synchroniser. An optional noise filter follows, and it only accepts a new level after four consecutive samples agree. An edge detector then compares the current qualified level with the previous one. On a matching edge the current timer count is loaded into the capture register and the capture flag is raised. The flag drives an interrupt request while the interrupt is enabled.

The capture register can also act as the period limit of the timer. This is selected with `top_mode`. In that mode the pin is ignored. The flag is set instead each time the timer reports that it has reached its limit (`at_top`). In this mode software loads the limit through the direct-write port. The flag is cleared by a write-one-to-clear strobe or by an interrupt acknowledge. A hardware set in the same cycle takes priority over either clear.

There are two state machines. The filter machine has the states FLT_HOLD and FLT_PEND:
- FLT_HOLD means the sample equals the accepted level.
- FLT_HOLD goes to FLT_PEND on the first differing sample.
- FLT_PEND goes back to FLT_HOLD on an agreeing sample.
- FLT_PEND also goes to FLT_HOLD, with the level flipped, on the fourth differing sample in a row.

The edge machine has the states LVL_LO and LVL_HI. It moves LVL_LO to LVL_HI on a high level, which is a rise event. It moves LVL_HI to LVL_LO on a low level, which is a fall event.

Top module: `icap_unit`

## Requirements
- R1: After reset, `cap_reg` is 0, `cap_flag` is 0 and `irq` is 0.
- R2: With `filt_en`=0, a pin change is captured at the third rising clock edge after the pin settles. The captured value is the `tmr_count` present at that edge.
- R3: `edge_rise`=1 captures only on a low-to-high pin transition. `edge_rise`=0 captures only on a high-to-low transition. A capture sets `cap_flag`.
- R4: With `filt_en`=1, the capture happens four clock cycles later than in R2, at the seventh edge.
- R5: With `filt_en`=1, a pin pulse lasting 1 to 3 cycles is rejected and produces no capture. A pulse of 4 or more cycles is accepted.
- R6: With `top_mode`=1, pin edges are ignored and leave `cap_reg` and `cap_flag` unchanged. A one-cycle `at_top` pulse sets `cap_flag`.
- R7: A cycle with `sw_wr_en`=1 loads `sw_wr_data` into `cap_reg` at the next edge. If a capture happens in the same cycle, the timer count is stored and the write is lost.
- R8: A cycle with `flag_clr`=1 clears `cap_flag`.
- R9: A cycle with `irq_ack`=1 clears `cap_flag`.
- R10: If a flag-setting event and a clear happen in the same cycle, `cap_flag` ends up 1.
- R11: `irq` is 1 exactly when `cap_flag`=1 and `irq_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture input |
| tmr_count | input | 16 | Current timer count |
| filt_en | input | 1 | Noise filter enable |
| edge_rise | input | 1 | 1 selects rising edge, 0 selects falling edge |
| top_mode | input | 1 | Capture register is the timer period limit |
| at_top | input | 1 | Timer reached its limit (used in top mode) |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| sw_wr_en | input | 1 | Direct write strobe for the capture register |
| sw_wr_data | input | 16 | Direct write data |
| cap_reg | output | 16 | Capture register |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a software write that lands in the same cycle as a capture. Reaching it needs exact knowledge of the synchroniser and edge latency. The bench therefore changes the pin half a cycle before a clock edge and counts the register stages. It raises the write strobe in the cycle that ends at the third edge, and it expects the timer count there, not the written data.

The filter threshold is also probed from both sides. A sweep over pulse widths of 1 to 5 cycles is run, together with every combination of filter enable, edge select and pin direction. The expected capture values come from cycle arithmetic on a timer count that the bench drives itself.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic {
        FLT_HOLD = 1'b0,
        FLT_PEND = 1'b1
    } filt_state_e;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_state_e;

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= RST_LVL;
                else        sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= {STAGES{RST_LVL}};
                else        sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];

endmodule

// File: rtl/icap_filter.sv
module icap_filter
    import icap_pkg::*;
#(
    parameter int   FILT_LEN = 4,
    parameter logic RST_LVL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic smp,
    output logic lvl_o
);

    localparam int CNT_W = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_LEN - 1);

    filt_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             lvl_q, lvl_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_HOLD;
            cnt_q   <= '0;
            lvl_q   <= RST_LVL;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lvl_q   <= lvl_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lvl_d   = lvl_q;
        if (!en) begin
            // bypassed: track the sample so enabling causes no jump
            state_d = FLT_HOLD;
            cnt_d   = '0;
            lvl_d   = smp;
        end else begin
            unique case (state_q)
                FLT_HOLD: begin
                    if (smp != lvl_q) begin
                        state_d = FLT_PEND;
                        cnt_d   = CNT_W'(1);
                    end
                end
                FLT_PEND: begin
                    if (smp == lvl_q) begin
                        state_d = FLT_HOLD;
                        cnt_d   = '0;
                    end else if (cnt_q == LAST) begin
                        state_d = FLT_HOLD;
                        cnt_d   = '0;
                        lvl_d   = smp;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    state_d = FLT_HOLD;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // output
    assign lvl_o = en ? lvl_q : smp;

endmodule

// File: rtl/icap_edge.sv
module icap_edge
    import icap_pkg::*;
#(
    parameter logic RST_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise_o,
    output logic fall_o
);

    lvl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_LVL ? LVL_HI : LVL_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            LVL_LO:  state_d = lvl ? LVL_HI : LVL_LO;
            LVL_HI:  state_d = lvl ? LVL_HI : LVL_LO;
            default: state_d = LVL_LO;
        endcase
    end

    assign rise_o = (state_q == LVL_LO) &&  lvl;
    assign fall_o = (state_q == LVL_HI) && !lvl;

endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
    parameter int   CNT_W       = 16,
    parameter int   SYNC_STAGES = 2,
    parameter int   FILT_LEN    = 4,
    parameter logic IDLE_LVL    = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic [CNT_W-1:0] tmr_count,
    input  logic             filt_en,
    input  logic             edge_rise,
    input  logic             top_mode,
    input  logic             at_top,
    input  logic             irq_en,
    input  logic             flag_clr,
    input  logic             irq_ack,
    input  logic             sw_wr_en,
    input  logic [CNT_W-1:0] sw_wr_data,
    output logic [CNT_W-1:0] cap_reg,
    output logic             cap_flag,
    output logic             irq
);

    logic pin_s;
    logic lvl_q;
    logic rise_ev;
    logic fall_ev;
    logic cap_evt;
    logic hw_set;

    icap_sync #(.STAGES(SYNC_STAGES), .RST_LVL(IDLE_LVL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cap_pin),
        .q     (pin_s)
    );

    icap_filter #(.FILT_LEN(FILT_LEN), .RST_LVL(IDLE_LVL)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (filt_en),
        .smp   (pin_s),
        .lvl_o (lvl_q)
    );

    icap_edge #(.RST_LVL(IDLE_LVL)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (lvl_q),
        .rise_o (rise_ev),
        .fall_o (fall_ev)
    );

    assign cap_evt = !top_mode && (edge_rise ? rise_ev : fall_ev);
    assign hw_set  = cap_evt || (top_mode && at_top);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cap_reg <= '0;
        else if (cap_evt)  cap_reg <= tmr_count;
        else if (sw_wr_en) cap_reg <= sw_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cap_flag <= 1'b0;
        else if (hw_set)                cap_flag <= 1'b1;
        else if (flag_clr || irq_ack)   cap_flag <= 1'b0;
    end

    assign irq = cap_flag && irq_en;

endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] tmr_count,
    input logic             top_mode,
    input logic             at_top,
    input logic             flag_clr,
    input logic             irq_ack,
    input logic             sw_wr_en,
    input logic [CNT_W-1:0] cap_reg,
    input logic             cap_flag,
    input logic             irq,
    input logic             cap_evt,
    input logic             hw_set
);

    // R6
    top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_mode && !sw_wr_en) |=> (cap_reg == $past(cap_reg)));

    // R7
    cap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_reg == $past(tmr_count)));

    // R7
    reg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_evt && !sw_wr_en) |=> $stable(cap_reg));

    // R8
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_clr || irq_ack) && !hw_set) |=> !cap_flag);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_mode && at_top) |=> cap_flag);

    // R11
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cap_flag);

endmodule

bind icap_unit icap_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_count (tmr_count),
    .top_mode  (top_mode),
    .at_top    (at_top),
    .flag_clr  (flag_clr),
    .irq_ack   (irq_ack),
    .sw_wr_en  (sw_wr_en),
    .cap_reg   (cap_reg),
    .cap_flag  (cap_flag),
    .irq       (irq),
    .cap_evt   (cap_evt),
    .hw_set    (hw_set)
);

// File: tb/icap_unit_tb.sv
module icap_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_pin = 1'b0;
    logic [15:0] tmr_count = 16'h0100;
    logic        filt_en = 1'b0;
    logic        edge_rise = 1'b0;
    logic        top_mode = 1'b0;
    logic        at_top = 1'b0;
    logic        irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        irq_ack = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [15:0] sw_wr_data = '0;
    logic [15:0] cap_reg;
    logic        cap_flag;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [15:0] t0;
    logic [15:0] saved;

    always #10 clk = ~clk;

    always @(negedge clk) tmr_count <= tmr_count + 16'd1;

    icap_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .tmr_count(tmr_count),
        .filt_en(filt_en), .edge_rise(edge_rise), .top_mode(top_mode),
        .at_top(at_top), .irq_en(irq_en), .flag_clr(flag_clr),
        .irq_ack(irq_ack), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .cap_reg(cap_reg), .cap_flag(cap_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic nxt(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pin_to(input logic v);
        nxt(1);
        cap_pin = v;
        t0 = tmr_count;
    endtask

    task automatic clear_flag();
        nxt(1); flag_clr = 1'b1;
        nxt(1); flag_clr = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        nxt(3);
        // R1 reset state
        chk(cap_reg == 16'h0 && !cap_flag && !irq, "R1 reset", {cap_reg, cap_flag, irq}, 0);
        rst_n = 1'b1;
        nxt(5);

        // R2 R3 R4 sweep: filter x edge select x direction
        for (int f = 0; f < 2; f++) begin
            for (int e = 0; e < 2; e++) begin
                for (int d = 0; d < 2; d++) begin
                    int  lat;
                    bit  hit;
                    filt_en   = f[0];
                    edge_rise = e[0];
                    cap_pin   = ~d[0];
                    nxt(12);
                    clear_flag();
                    saved = cap_reg;
                    lat = f ? 7 : 3;
                    hit = (e == d);
                    pin_to(d[0]);
                    nxt(lat - 1);
                    chk(!cap_flag && cap_reg == saved, "R4 R2 no early capture", cap_reg, saved);
                    nxt(1);
                    if (hit)
                        chk(cap_flag && cap_reg == t0 + 16'(lat - 1),
                            f ? "R4 filtered capture" : "R2 R3 capture", cap_reg, t0 + 16'(lat - 1));
                    else
                        chk(!cap_flag && cap_reg == saved, "R3 wrong edge ignored", cap_reg, saved);
                end
            end
        end

        // R5 glitch width sweep with filter on
        filt_en = 1'b1; edge_rise = 1'b1; cap_pin = 1'b0;
        for (int w = 1; w <= 5; w++) begin
            nxt(12);
            clear_flag();
            saved = cap_reg;
            pin_to(1'b1);
            nxt(w);
            cap_pin = 1'b0;
            nxt(12);
            if (w >= 4)
                chk(cap_flag && cap_reg == t0 + 16'd6, "R5 long pulse accepted", cap_reg, t0 + 16'd6);
            else
                chk(!cap_flag && cap_reg == saved, "R5 short pulse rejected", {cap_flag, cap_reg}, saved);
        end

        // R7 write collides with capture
        filt_en = 1'b0; edge_rise = 1'b1; cap_pin = 1'b0;
        nxt(10);
        clear_flag();
        pin_to(1'b1);
        nxt(2);
        sw_wr_en = 1'b1; sw_wr_data = 16'hBEEF;
        nxt(1);
        sw_wr_en = 1'b0;
        chk(cap_reg == t0 + 16'd2, "R7 capture beats write", cap_reg, t0 + 16'd2);
        nxt(1);
        sw_wr_en = 1'b1; sw_wr_data = 16'h00A5;
        nxt(1);
        sw_wr_en = 1'b0;
        chk(cap_reg == 16'h00A5, "R7 plain write", cap_reg, 16'h00A5);

        // R8 write-one-to-clear
        chk(cap_flag, "R8 flag set before clear", cap_flag, 1);
        clear_flag();
        chk(!cap_flag, "R8 flag cleared", cap_flag, 0);

        // R6 top mode ignores pin
        top_mode = 1'b1;
        saved = cap_reg;
        pin_to(1'b0);
        nxt(10);
        pin_to(1'b1);
        nxt(10);
        chk(!cap_flag && cap_reg == saved, "R6 pin ignored in top mode", cap_reg, saved);
        sw_wr_en = 1'b1; sw_wr_data = 16'h3C5A;
        nxt(1);
        sw_wr_en = 1'b0;
        chk(cap_reg == 16'h3C5A, "R6 R7 period write", cap_reg, 16'h3C5A);
        at_top = 1'b1;
        nxt(1);
        at_top = 1'b0;
        chk(cap_flag && cap_reg == 16'h3C5A, "R6 at_top sets flag", cap_flag, 1);

        // R11 interrupt gating
        irq_en = 1'b0;
        nxt(1);
        chk(!irq, "R11 irq masked", irq, 0);
        irq_en = 1'b1;
        #1;
        chk(irq, "R11 irq raised", irq, 1);

        // R9 acknowledge clears
        nxt(1); irq_ack = 1'b1;
        nxt(1); irq_ack = 1'b0;
        chk(!cap_flag && !irq, "R9 ack clears flag", cap_flag, 0);

        // R10 set beats clear
        at_top = 1'b1; flag_clr = 1'b1; irq_ack = 1'b1;
        nxt(1);
        at_top = 1'b0; flag_clr = 1'b0; irq_ack = 1'b0;
        chk(cap_flag, "R10 set wins over clear", cap_flag, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule